// File: doc/BRIEF.md
# General-Purpose Event Status and Interrupt Controller

This block holds the flags and enables for general-purpose power-management events, plus the one interrupt line that software sees. Each bit of a 32-bit event input is a pulse from an event source. Bits 31 and 30 carry mapper lines 7 and 6, and bits 21 down to 17 carry mapper lines 5 down to 1. A pulse sets a sticky flag at the same bit position. The flag stays set until software clears it by writing a 1 to it. The interrupt output is the OR, over all bit positions, of each flag ANDed with its enable bit. The output is registered and is level-sensitive.

The flags belong to two power domains. Flags 23..0 are in the working domain. While the `standby` input is high, these flags are held at zero. Flags 31..24 are in the standby domain. They keep their values through standby and can still be set during it. Bits 29..22 are reserved in both registers. They hold no state, read as zero and ignore both writes and events.

Software reaches the two registers over a simple register bus. The bus has a valid strobe, a write flag, an 8-bit byte offset and 32-bit data, and read data returns in the same cycle.

Top module: `gpe_event_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), the flag register and the enable register both read 00000000h and `sci` is 0.
- R2: A bus write to offset 18h clears every flag whose `bus_wdata` bit is 1. Flags whose `bus_wdata` bit is 0 keep their value.
- R3: While `standby` is high at a rising edge, flags 23..0 become 0 whatever the event inputs are. Flags 31..24 keep their value and can still be set by events.
- R4: `sci` equals the OR over all bit positions of (flag AND enable bit), taken one rising edge after the flags and enables hold those values. `sci` stays high until the flag or the enable that causes it is cleared.
- R5: Bits 29..22 of both registers always read 0. Writes and event pulses at those positions have no effect.
- R6: A high event input bit at a rising edge sets the matching non-reserved flag. The flag stays set until it is cleared by R2 or R3.
- R7: If an event and a write-1 clear reach the same flag at the same edge, the flag ends up set.
- R8: A bus write to offset 1Ch loads the enable register, except at the reserved positions. It reads back at 1Ch and never changes any flag.
- R9: `bus_rdata` is combinational. When `bus_valid` is high and `bus_write` is low, it shows the register selected by `bus_offset`: 18h selects the flags and 1Ch selects the enables. Any other offset, a write cycle or an idle bus gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_offset | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| gpe_evt | input | 32 | Per-bit event pulses |
| standby | input | 1 | Standby indication; clears flags 23..0 while high |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
Three results have three different due times. Read data is due in the cycle of the access. A flag changes at the first rising edge that sees its event, clear or standby input. `sci` follows one edge after that. The bench drives each access shortly after a rising edge and queues the expected read data and `sci` level. A monitor compares them at the next falling edge. That falling edge lies after the combinational read has settled and before the edge that would commit the access.

// File: rtl/gpe_pkg.sv
// Package: shared defaults and the bus access decode type for the
// general-purpose event controller.
package gpe_pkg;

    localparam int GPE_DATA_W   = 32;
    localparam int GPE_ADDR_W   = 8;
    localparam int GPE_WORK_W   = 24;
    localparam int GPE_RSVD_LO  = 22;
    localparam int GPE_RSVD_HI  = 29;
    localparam int GPE_STS_OFF  = 'h18;
    localparam int GPE_EN_OFF   = 'h1C;

    // One decoded bus access per cycle.
    typedef enum logic [2:0] {
        ACC_IDLE   = 3'd0,
        ACC_STS_RD = 3'd1,
        ACC_STS_WR = 3'd2,
        ACC_EN_RD  = 3'd3,
        ACC_EN_WR  = 3'd4,
        ACC_MISS   = 3'd5
    } gpe_acc_e;

endpackage

// File: rtl/gpe_bus_decode.sv
// gpe_bus_decode: turns the valid/write/offset triple into one access kind.
// Assumes at most one access per cycle and exact offset matching (no aliasing).
module gpe_bus_decode
    import gpe_pkg::*;
#(
    parameter int ADDR_W     = GPE_ADDR_W,
    parameter int STS_OFFSET = GPE_STS_OFF,
    parameter int EN_OFFSET  = GPE_EN_OFF
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_offset,
    output gpe_acc_e          acc
);

    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFFSET);
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_OFFSET);

    // Classify the current bus cycle.
    always_comb begin
        if (!bus_valid) begin
            acc = ACC_IDLE;
        end else if (bus_offset == STS_A) begin
            acc = bus_write ? ACC_STS_WR : ACC_STS_RD;
        end else if (bus_offset == EN_A) begin
            acc = bus_write ? ACC_EN_WR : ACC_EN_RD;
        end else begin
            acc = ACC_MISS;
        end
    end

endmodule

// File: rtl/gpe_flag_cell.sv
// gpe_flag_cell: one sticky event flag.
// Priority at each edge: domain wipe, then event set, then software clear.
// KEEP=0 makes a reserved position that never leaves 0.
// WIPE_EN=0 makes a standby-domain flag that ignores the wipe input.
module gpe_flag_cell #(
    parameter bit KEEP    = 1'b1,
    parameter bit WIPE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic wipe,
    output logic flag
);

    logic flag_q;
    logic flag_d;

    // Next-state rule: a wipe beats an event, and an event beats a clear.
    always_comb begin
        if (wipe && WIPE_EN) begin
            flag_d = 1'b0;
        end else if (evt) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
        flag_d = flag_d & KEEP;
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/gpe_status_bank.sv
// gpe_status_bank: the full row of event flags. Each bit gets a flag cell
// configured by its domain and by whether it is reserved.
// Assumes clr_vec is already qualified by a status-register write.
module gpe_status_bank #(
    parameter int               DATA_W    = 32,
    parameter int               WORK_W    = 24,
    parameter logic [DATA_W-1:0] RSVD_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_vec,
    input  logic [DATA_W-1:0] clr_vec,
    input  logic              standby,
    output logic [DATA_W-1:0] flags
);

    // One cell per bit position; the parameters pick the variant.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        gpe_flag_cell #(
            .KEEP   (!RSVD_MASK[i]),
            .WIPE_EN(i < WORK_W)
        ) u_cell (
            .clk (clk),
            .rst_n(rst_n),
            .evt (evt_vec[i]),
            .clr (clr_vec[i]),
            .wipe(standby),
            .flag(flags[i])
        );
    end

endmodule

// File: rtl/gpe_enable_reg.sv
// gpe_enable_reg: plain read/write enable register. Reserved positions are
// masked on load, so they hold 0 and read back 0.
module gpe_enable_reg #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] RSVD_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] enables
);

    logic [DATA_W-1:0] en_q;

    // Load the masked write data on an enable-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (load) begin
            en_q <= wdata & ~RSVD_MASK;
        end
    end

    assign enables = en_q;

endmodule

// File: rtl/gpe_sci_gen.sv
// gpe_sci_gen: registered AND-OR reduction of the flags and enables into the
// interrupt level. The register adds one cycle of latency by design.
module gpe_sci_gen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] enables,
    output logic              sci
);

    logic sci_q;

    // Sample the reduced interrupt request each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_q <= 1'b0;
        end else begin
            sci_q <= |(flags & enables);
        end
    end

    assign sci = sci_q;

endmodule

// File: rtl/gpe_event_ctrl.sv
// gpe_event_ctrl: top level of the general-purpose event controller.
// It ties together the decode, the flag bank, the enable register, the
// interrupt generator and the combinational read mux.
// Assumes the event inputs are synchronous to clk.
module gpe_event_ctrl
    import gpe_pkg::*;
#(
    parameter int DATA_W     = GPE_DATA_W,
    parameter int ADDR_W     = GPE_ADDR_W,
    parameter int WORK_W     = GPE_WORK_W,
    parameter int RSVD_LO    = GPE_RSVD_LO,
    parameter int RSVD_HI    = GPE_RSVD_HI,
    parameter int STS_OFFSET = GPE_STS_OFF,
    parameter int EN_OFFSET  = GPE_EN_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_offset,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] gpe_evt,
    input  logic              standby,
    output logic              sci
);

    localparam logic [DATA_W-1:0] ONES      = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] RSVD_MASK =
        (ONES >> (DATA_W - 1 - RSVD_HI)) & (ONES << RSVD_LO);

    gpe_acc_e          acc;
    logic [DATA_W-1:0] sts_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] clr_vec;

    gpe_bus_decode #(
        .ADDR_W    (ADDR_W),
        .STS_OFFSET(STS_OFFSET),
        .EN_OFFSET (EN_OFFSET)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_offset(bus_offset),
        .acc       (acc)
    );

    // The write-1-to-clear vector applies only on a status-register write.
    always_comb begin
        clr_vec = (acc == ACC_STS_WR) ? bus_wdata : '0;
    end

    gpe_status_bank #(
        .DATA_W   (DATA_W),
        .WORK_W   (WORK_W),
        .RSVD_MASK(RSVD_MASK)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_vec(gpe_evt),
        .clr_vec(clr_vec),
        .standby(standby),
        .flags  (sts_q)
    );

    gpe_enable_reg #(
        .DATA_W   (DATA_W),
        .RSVD_MASK(RSVD_MASK)
    ) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (acc == ACC_EN_WR),
        .wdata  (bus_wdata),
        .enables(en_q)
    );

    gpe_sci_gen #(
        .DATA_W(DATA_W)
    ) u_sci (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (sts_q),
        .enables(en_q),
        .sci    (sci)
    );

    // Read-back mux: the same-cycle value of the selected register, else zero.
    always_comb begin
        case (acc)
            ACC_STS_RD: bus_rdata = sts_q;
            ACC_EN_RD:  bus_rdata = en_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpe_event_ctrl_chk.sv
// gpe_event_ctrl_chk: protocol and state properties of gpe_event_ctrl.
// It is attached by the bind at the bottom of this file and watches the
// ports plus the two internal register rows.
module gpe_event_ctrl_chk #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int WORK_W     = 24,
    parameter int RSVD_LO    = 22,
    parameter int RSVD_HI    = 29,
    parameter int STS_OFFSET = 'h18,
    parameter int EN_OFFSET  = 'h1C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_offset,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] gpe_evt,
    input logic              standby,
    input logic              sci,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] enable_q
);

    localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] RSVD  =
        (ONES >> (DATA_W - 1 - RSVD_HI)) & (ONES << RSVD_LO);
    localparam logic [DATA_W-1:0] WORKM = ONES >> (DATA_W - WORK_W);

    logic              wr_sts;
    logic              wr_en;
    logic              rd_miss;
    logic [DATA_W-1:0] keep;

    // Independent view of the access kind and of the flags an event must set.
    always_comb begin
        wr_sts  = bus_valid && bus_write && (bus_offset == ADDR_W'(STS_OFFSET));
        wr_en   = bus_valid && bus_write && (bus_offset == ADDR_W'(EN_OFFSET));
        rd_miss = bus_valid && !bus_write &&
                  (bus_offset != ADDR_W'(STS_OFFSET)) &&
                  (bus_offset != ADDR_W'(EN_OFFSET));
        keep    = ~RSVD & (standby ? ~WORKM : ONES);
    end

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts |=> ((status_q & $past(bus_wdata & ~gpe_evt)) == '0));

    assert_standby_wipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ((status_q & WORKM) == '0));

    assert_sci_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sci == $past(|(status_q & enable_q))));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & RSVD) == '0) && ((enable_q & RSVD) == '0) &&
        ((bus_rdata & RSVD) == '0));

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gpe_evt & keep)) |=> ((status_q & $past(gpe_evt & keep)) ==
                                 $past(gpe_evt & keep)));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sts && !standby) |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && !standby && |(gpe_evt & bus_wdata & ~RSVD)) |=>
        ((status_q & $past(gpe_evt & bus_wdata & ~RSVD)) ==
         $past(gpe_evt & bus_wdata & ~RSVD)));

    assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (enable_q == $past(bus_wdata & ~RSVD)));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_miss || !bus_valid || bus_write) |-> (bus_rdata == '0));

endmodule

bind gpe_event_ctrl gpe_event_ctrl_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .WORK_W    (WORK_W),
    .RSVD_LO   (RSVD_LO),
    .RSVD_HI   (RSVD_HI),
    .STS_OFFSET(STS_OFFSET),
    .EN_OFFSET (EN_OFFSET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_offset(bus_offset),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpe_evt   (gpe_evt),
    .standby   (standby),
    .sci       (sci),
    .status_q  (sts_q),
    .enable_q  (en_q)
);

// File: tb/tb_gpe_event_ctrl.sv
// Scoreboard bench for gpe_event_ctrl. The driver applies one bus cycle per
// clock, 2 ns after the rising edge, and pushes the expected read data and
// sci level into queues. The monitor pops them at the falling edge.
module tb_gpe_event_ctrl;

    localparam logic [31:0] RSVD  = 32'h3FC0_0000;  // bits 29..22
    localparam logic [31:0] WORKM = 32'h00FF_FFFF;  // bits 23..0
    localparam logic [7:0]  OFF_S = 8'h18;
    localparam logic [7:0]  OFF_E = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_offset = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gpe_evt = '0;
    logic        standby = 1'b0;
    logic        sci;

    int checks = 0;
    int errors = 0;

    // Reference state and the values pending for the next edge.
    logic [31:0] m_sts = '0, m_en = '0, n_sts = '0, n_en = '0;
    logic        m_sci = 1'b0, n_sci = 1'b0;

    logic [31:0] q_rd[$];
    logic        q_sci[$];
    string       q_tag[$];

    always #10 clk = ~clk;  // 50 MHz

    gpe_event_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_offset(bus_offset),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpe_evt   (gpe_evt),
        .standby   (standby),
        .sci       (sci)
    );

    // Driver: one bus cycle. It commits the model at the edge, drives the
    // inputs, queues the expectation and computes the next model state.
    task automatic step(input logic v, input logic w, input logic [7:0] off,
                        input logic [31:0] wd, input logic [31:0] ev,
                        input logic sb, input bit chk, input string tag);
        logic [31:0] clr;
        logic [31:0] rd;
        @(posedge clk);
        m_sts = n_sts; m_en = n_en; m_sci = n_sci;
        #2;
        bus_valid = v; bus_write = w; bus_offset = off;
        bus_wdata = wd; gpe_evt = ev; standby = sb;
        rd = '0;
        if (v && !w && off == OFF_S) rd = m_sts;
        if (v && !w && off == OFF_E) rd = m_en;
        if (chk) begin
            q_rd.push_back(rd); q_sci.push_back(m_sci); q_tag.push_back(tag);
        end
        clr   = (v && w && off == OFF_S) ? wd : '0;
        n_sts = ((m_sts & ~clr) | ev) & ~RSVD;
        if (sb) n_sts = n_sts & ~WORKM;
        n_en  = (v && w && off == OFF_E) ? (wd & ~RSVD) : m_en;
        n_sci = |(m_sts & m_en);
    endtask

    task automatic rd(input logic [7:0] off, input string tag);
        step(1'b1, 1'b0, off, '0, '0, 1'b0, 1'b1, tag);
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] wd,
                      input logic [31:0] ev, input string tag);
        step(1'b1, 1'b1, off, wd, ev, 1'b0, 1'b1, tag);
    endtask

    task automatic reset_pulse();
        @(posedge clk);
        #2;
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        gpe_evt = '0; standby = 1'b0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        m_sts = '0; m_en = '0; m_sci = 1'b0;
        n_sts = '0; n_en = '0; n_sci = 1'b0;
    endtask

    // Monitor: compare each queued expectation at the falling edge.
    always @(negedge clk) begin
        while (q_tag.size() > 0) begin
            logic [31:0] er;
            logic        es;
            string       t;
            er = q_rd.pop_front(); es = q_sci.pop_front(); t = q_tag.pop_front();
            checks++;
            if (bus_rdata !== er) begin
                errors++;
                $display("FAIL %s: rdata actual %08h expected %08h", t, bus_rdata, er);
            end
            checks++;
            if (sci !== es) begin
                errors++;
                $display("FAIL %s: sci actual %0b expected %0b (R4)", t, sci, es);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state.
        rd(OFF_S, "R1 flags after reset");
        rd(OFF_E, "R1 enables after reset");
        // R9: idle bus, write cycle and unmapped offset all return zero.
        step(1'b0, 1'b0, OFF_S, '0, '0, 1'b0, 1'b1, "R9 idle bus reads zero");
        rd(8'h10, "R9 unmapped offset reads zero");
        // R6: an event sets a sticky flag.
        step(1'b0, 1'b0, '0, '0, 32'h0000_0001, 1'b0, 1'b0, "");
        rd(OFF_S, "R6 event sets flag 0");
        rd(OFF_S, "R6 flag 0 stays set");
        // R5: all events high; the reserved bits stay 0.
        step(1'b0, 1'b0, '0, '0, 32'hFFFF_FFFF, 1'b0, 1'b0, "");
        rd(OFF_S, "R5 reserved flags read zero");
        wr(OFF_S, RSVD, '0, "R5 write to reserved status bits");
        rd(OFF_S, "R5 reserved write changes nothing");
        // R8: the enable register loads, masks reserved bits, leaves flags alone.
        wr(OFF_E, 32'hFFFF_FFFF, '0, "R8 enable write cycle reads zero R9");
        rd(OFF_E, "R8 enable read back");
        rd(OFF_S, "R8 flags unchanged by enable write");
        rd(OFF_S, "R4 sci high from enabled flags");
        // R2: write 1 clears, write 0 keeps.
        wr(OFF_S, 32'h0000_0001, '0, "R2 clear flag 0");
        rd(OFF_S, "R2 flag 0 cleared");
        wr(OFF_S, 32'h0000_0000, '0, "R2 write zero");
        rd(OFF_S, "R2 write zero keeps flags");
        // R7: an event and a clear on the same flag at the same edge.
        wr(OFF_S, 32'h0000_0003, 32'h0000_0002, "R7 event with clear");
        rd(OFF_S, "R7 event wins, flag 0 cleared");
        // R3: standby wipes the working domain and keeps the standby domain.
        wr(OFF_S, 32'hFFFF_FFFF, '0, "R3 clear all");
        step(1'b0, 1'b0, '0, '0, 32'h0100_0000, 1'b0, 1'b0, "");
        step(1'b1, 1'b0, OFF_S, '0, 32'h8000_0020, 1'b1, 1'b1, "R3 standby begins");
        step(1'b1, 1'b0, OFF_S, '0, 32'h0000_0040, 1'b1, 1'b1,
             "R3 during standby low flags wiped");
        rd(OFF_S, "R3 after standby high flags kept");
        // R4: sci follows the enables and then the flags.
        wr(OFF_E, 32'h0000_0001, '0, "R4 enable only bit 0");
        rd(OFF_S, "R4 sci drops one cycle later");
        rd(OFF_S, "R4 sci low");
        wr(OFF_E, 32'h8000_0000, '0, "R4 enable bit 31");
        rd(OFF_E, "R4 sci rises one cycle later");
        rd(OFF_E, "R4 sci high");
        wr(OFF_S, 32'h8000_0000, '0, "R4 clear causing flag");
        rd(OFF_S, "R4 sci still high for one cycle");
        rd(OFF_S, "R4 sci low after clear");
        // R1: reset from a dirty state.
        step(1'b0, 1'b0, '0, '0, 32'h8000_0003, 1'b0, 1'b0, "");
        wr(OFF_E, 32'hFFFF_FFFF, '0, "R1 setup before reset");
        reset_pulse();
        rd(OFF_S, "R1 flags zero after second reset");
        rd(OFF_E, "R1 enables zero after second reset");

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule